// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block turns a free-running pixel clock into the timing strobes of a video raster. A pixel counter runs across each line and a line counter runs down each frame. From these it forms horizontal sync, horizontal blanking, vertical sync and vertical blanking, plus a field flag that separates the two halves of an interlaced frame. Every format number is a plain input: pixels per line, active pixels, sync start and stop on the line, lines per frame, active lines, and sync start and stop on the field. A single mode input picks progressive or interlaced scanning.

Each of the five standard strobes has its own polarity-invert bit, so the block can drive sinks that expect either sense. On top of the standard strobes there are two free windows: a horizontal one placed by pixel position and a vertical one placed by frame line number. Both are guarded: a window whose start is not below its stop, or whose stop lies beyond the raster, stays low instead of wrapping. All outputs come from one register stage, so they move together and keep a fixed one-cycle lag behind the counters. The block has no data stream, so no pin carries a valid/ready handshake and nothing can stall it.

Top module: `vtg_top`

## Requirements
- R1: While `rst_n` is low, `hsync_o`, `hblank_o`, `vsync_o` and `vblank_o` read 1, and `field_o`, `user_h_o` and `user_v_o` read 0.
- R2: The pixel position counts 0 up to `h_total`-1 and then returns to 0. The line number moves up by one on each return and goes back to 0 after line `v_total`-1.
- R3: With `pol_inv[0]`=0, `hsync_o` is low while the pixel position p satisfies `hs_start` <= p < `hs_stop` and high otherwise. It stays high when `hs_start` >= `hs_stop`. With `pol_inv[0]`=1 the output is the complement.
- R4: With `pol_inv[1]`=0, `hblank_o` is low for pixel positions below `h_active` and high from `h_active` onward. `pol_inv[1]`=1 complements it.
- R5: With `pol_inv[2]`=0, `vsync_o` is low while the line within the field L satisfies `vs_start` <= L < `vs_stop` and high otherwise, with no pulse when `vs_start` >= `vs_stop`. `pol_inv[2]`=1 complements it.
- R6: With `pol_inv[3]`=0, `vblank_o` is low for lines within the field below `v_active` and high from `v_active` onward. `pol_inv[3]`=1 complements it.
- R7: With `interlaced`=0 the field flag is 1 on every line, and the line within the field equals the frame line. With `interlaced`=1, let H = ceil(`v_total`/2). Frame lines below H are field 1 (flag 1, line within field = frame line). Later lines are field 2 (flag 0, line within field = frame line - H). `field_o` shows the flag, complemented when `pol_inv[4]`=1.
- R8: `user_h_o` is high while `uh_start` <= pixel position < `uh_stop`, and only if `uh_start` < `uh_stop` and `uh_stop` <= `h_total`. Otherwise it stays low.
- R9: `user_v_o` is high while `uv_start` <= frame line < `uv_stop`, and only if `uv_start` < `uv_stop` and `uv_stop` <= `v_total`. Otherwise it stays low. The frame line count starts at the first line of field 1.
- R10: Every output is registered. The value seen after a clock edge follows from the counter position and the inputs present at that edge, including the invert bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_total | input | 16 | Pixels per line |
| h_active | input | 16 | Active pixels at the start of a line |
| hs_start | input | 16 | First pixel of horizontal sync |
| hs_stop | input | 16 | First pixel after horizontal sync |
| v_total | input | 15 | Lines per frame |
| v_active | input | 15 | Active lines at the start of a field |
| vs_start | input | 15 | First field line of vertical sync |
| vs_stop | input | 15 | First field line after vertical sync |
| interlaced | input | 1 | 1 selects two fields per frame |
| pol_inv | input | 5 | Invert bits: 0 hsync, 1 hblank, 2 vsync, 3 vblank, 4 field |
| uh_start | input | 16 | User horizontal window start pixel |
| uh_stop | input | 16 | User horizontal window stop pixel |
| uv_start | input | 15 | User vertical window start frame line |
| uv_stop | input | 15 | User vertical window stop frame line |
| hsync_o | output | 1 | Horizontal sync |
| hblank_o | output | 1 | Horizontal blanking |
| vsync_o | output | 1 | Vertical sync |
| vblank_o | output | 1 | Vertical blanking |
| field_o | output | 1 | Field flag |
| user_h_o | output | 1 | User horizontal window |
| user_v_o | output | 1 | User vertical window |

## Verification
Every output depends on the counter position at one rising edge and appears just after that edge. The line number changes on the same edge that returns the pixel position to 0. The bench model follows the same schedule. At each rising edge it derives all seven expected levels from its own pixel and line count and from the inputs then applied, and only after that does it step its counts. The comparison runs at the following falling edge, so a change to any input, such as an invert bit or a window bound, is expected to show exactly one edge later. Inputs only change on falling edges, so the design and the model always see the same values.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  // Bit order matches pol_inv: bit0 hsync .. bit4 field
  typedef struct packed {
    logic field;
    logic vblank;
    logic vsync;
    logic hblank;
    logic hsync;
  } vtg_lvl_t;

  localparam int unsigned VTG_NUM_STROBES = 5;

  localparam vtg_lvl_t VTG_RESET_LVL = '{
    field:  1'b0,
    vblank: 1'b1,
    vsync:  1'b1,
    hblank: 1'b1,
    hsync:  1'b1
  };

endpackage

// File: rtl/vtg_span.sv
module vtg_span #(
  parameter int unsigned W           = 16,
  parameter bit          CHECK_LIMIT = 1'b0
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] limit,
  output logic         hit
);

  logic well_formed;
  logic in_range;

  always_comb begin
    well_formed = (lo < hi);
    in_range    = (CHECK_LIMIT == 1'b0) || (hi <= limit);
    hit         = well_formed && in_range && (pos >= lo) && (pos < hi);
  end

endmodule

// File: rtl/vtg_raster_cnt.sv
module vtg_raster_cnt #(
  parameter int unsigned HW = 16,
  parameter int unsigned VW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_total,
  input  logic [VW-1:0] v_total,
  input  logic          interlaced,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic [VW-1:0] field_line,
  output logic          field_one
);

  logic          h_last;
  logic          v_last;
  logic [VW:0]   half_sum;
  logic [VW-1:0] half_lines;

  always_comb begin
    h_last     = (hcnt >= (h_total - 1'b1));
    v_last     = (vcnt >= (v_total - 1'b1));
    half_sum   = {1'b0, v_total} + 1'b1;
    half_lines = half_sum[VW:1];
    if (!interlaced) begin
      field_one  = 1'b1;
      field_line = vcnt;
    end else if (vcnt < half_lines) begin
      field_one  = 1'b1;
      field_line = vcnt;
    end else begin
      field_one  = 1'b0;
      field_line = vcnt - half_lines;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (h_last) begin
      hcnt <= '0;
      vcnt <= v_last ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  // R2: line end returns the pixel position to zero
  assert_h_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt >= (h_total - 1'b1)) |=> (hcnt == '0));

  // R2: inside a frame the line number advances by one at line end
  assert_v_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((hcnt >= (h_total - 1'b1)) && (vcnt < (v_total - 1'b1)) && (vcnt != '1))
    |=> (vcnt == $past(vcnt) + 1'b1));

  // R2: mid-line the line number holds
  assert_v_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt < (h_total - 1'b1)) |=> $stable(vcnt));

endmodule

// File: rtl/vtg_top.sv
module vtg_top #(
  parameter int unsigned HW = 16,
  parameter int unsigned VW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_total,
  input  logic [HW-1:0] h_active,
  input  logic [HW-1:0] hs_start,
  input  logic [HW-1:0] hs_stop,
  input  logic [VW-1:0] v_total,
  input  logic [VW-1:0] v_active,
  input  logic [VW-1:0] vs_start,
  input  logic [VW-1:0] vs_stop,
  input  logic          interlaced,
  input  logic [4:0]    pol_inv,
  input  logic [HW-1:0] uh_start,
  input  logic [HW-1:0] uh_stop,
  input  logic [VW-1:0] uv_start,
  input  logic [VW-1:0] uv_stop,
  output logic          hsync_o,
  output logic          hblank_o,
  output logic          vsync_o,
  output logic          vblank_o,
  output logic          field_o,
  output logic          user_h_o,
  output logic          user_v_o
);
  import vtg_pkg::*;

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [VW-1:0] field_line;
  logic          field_one;
  logic          hs_hit, vs_hit, uh_hit, uv_hit;
  vtg_lvl_t      lvl_d, lvl_q;
  logic          user_h_q, user_v_q;

  vtg_raster_cnt #(.HW(HW), .VW(VW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_total    (h_total),
    .v_total    (v_total),
    .interlaced (interlaced),
    .hcnt       (hcnt),
    .vcnt       (vcnt),
    .field_line (field_line),
    .field_one  (field_one)
  );

  vtg_span #(.W(HW), .CHECK_LIMIT(1'b0)) u_hs (
    .pos(hcnt), .lo(hs_start), .hi(hs_stop), .limit(h_total), .hit(hs_hit));

  vtg_span #(.W(VW), .CHECK_LIMIT(1'b0)) u_vs (
    .pos(field_line), .lo(vs_start), .hi(vs_stop), .limit(v_total), .hit(vs_hit));

  vtg_span #(.W(HW), .CHECK_LIMIT(1'b1)) u_uh (
    .pos(hcnt), .lo(uh_start), .hi(uh_stop), .limit(h_total), .hit(uh_hit));

  vtg_span #(.W(VW), .CHECK_LIMIT(1'b1)) u_uv (
    .pos(vcnt), .lo(uv_start), .hi(uv_stop), .limit(v_total), .hit(uv_hit));

  always_comb begin
    lvl_d.hsync  = ~hs_hit;
    lvl_d.hblank = (hcnt >= h_active);
    lvl_d.vsync  = ~vs_hit;
    lvl_d.vblank = (field_line >= v_active);
    lvl_d.field  = field_one;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= VTG_RESET_LVL;
      user_h_q <= 1'b0;
      user_v_q <= 1'b0;
    end else begin
      lvl_q    <= lvl_d ^ vtg_lvl_t'(pol_inv);
      user_h_q <= uh_hit;
      user_v_q <= uv_hit;
    end
  end

  assign hsync_o  = lvl_q.hsync;
  assign hblank_o = lvl_q.hblank;
  assign vsync_o  = lvl_q.vsync;
  assign vblank_o = lvl_q.vblank;
  assign field_o  = lvl_q.field;
  assign user_h_o = user_h_q;
  assign user_v_o = user_v_q;

  // R8: a malformed horizontal window never fires
  assert_uh_malformed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (uh_start >= uh_stop) |=> !user_h_o);

  // R8: a window reaching past the line never fires
  assert_uh_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (uh_stop > h_total) |=> !user_h_o);

  // R9: a window reaching past the frame never fires
  assert_uv_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((uv_stop > v_total) || (uv_start >= uv_stop)) |=> !user_v_o);

  // R7: progressive scan holds the field flag high
  assert_prog_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!interlaced && !pol_inv[4]) |=> field_o);

  // R4: active pixels are unblanked one edge later
  assert_hblank_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((hcnt < h_active) && !pol_inv[1]) |=> !hblank_o);

  // R3: outside the sync span the default-polarity sync is idle
  assert_hsync_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((hs_start >= hs_stop) && !pol_inv[0]) |=> hsync_o);

endmodule

// File: tb/sim_vtg_top.sv
module sim_vtg_top;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 16;
  localparam int VW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [HW-1:0] h_total = 16'd20, h_active = 16'd14, hs_start = 16'd15, hs_stop = 16'd17;
  logic [VW-1:0] v_total = 15'd12, v_active = 15'd8, vs_start = 15'd9, vs_stop = 15'd10;
  logic          interlaced = 1'b0;
  logic [4:0]    pol_inv = 5'd0;
  logic [HW-1:0] uh_start = 16'd0, uh_stop = 16'd0;
  logic [VW-1:0] uv_start = 15'd0, uv_stop = 15'd0;
  logic hsync_o, hblank_o, vsync_o, vblank_o, field_o, user_h_o, user_v_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vtg_top #(.HW(HW), .VW(VW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .h_total(h_total), .h_active(h_active), .hs_start(hs_start), .hs_stop(hs_stop),
    .v_total(v_total), .v_active(v_active), .vs_start(vs_start), .vs_stop(vs_stop),
    .interlaced(interlaced), .pol_inv(pol_inv),
    .uh_start(uh_start), .uh_stop(uh_stop), .uv_start(uv_start), .uv_stop(uv_stop),
    .hsync_o(hsync_o), .hblank_o(hblank_o), .vsync_o(vsync_o), .vblank_o(vblank_o),
    .field_o(field_o), .user_h_o(user_h_o), .user_v_o(user_v_o)
  );

  // Behavioural reference: integer raster position
  int mh = 0, mv = 0;
  bit in_rst = 1'b1;
  bit e_hs, e_hb, e_vs, e_vb, e_fd, e_uh, e_uv;

  always @(posedge clk) begin
    if (!rst_n) begin
      mh = 0; mv = 0; in_rst = 1'b1;
      e_hs = 1; e_hb = 1; e_vs = 1; e_vb = 1; e_fd = 0; e_uh = 0; e_uv = 0;
    end else begin
      int half, lif;
      bit f1;
      in_rst = 1'b0;
      half = (int'(v_total) + 1) / 2;
      if (!interlaced) begin f1 = 1; lif = mv; end
      else if (mv < half) begin f1 = 1; lif = mv; end
      else begin f1 = 0; lif = mv - half; end
      e_hs = !(mh >= hs_start && mh < hs_stop && hs_start < hs_stop) ^ pol_inv[0];
      e_hb = (mh >= h_active) ^ pol_inv[1];
      e_vs = !(lif >= vs_start && lif < vs_stop && vs_start < vs_stop) ^ pol_inv[2];
      e_vb = (lif >= v_active) ^ pol_inv[3];
      e_fd = f1 ^ pol_inv[4];
      e_uh = (uh_start < uh_stop) && (uh_stop <= h_total) && (mh >= uh_start) && (mh < uh_stop);
      e_uv = (uv_start < uv_stop) && (uv_stop <= v_total) && (mv >= uv_start) && (mv < uv_stop);
      if (mh >= int'(h_total) - 1) begin
        mh = 0;
        if (mv >= int'(v_total) - 1) mv = 0; else mv = mv + 1;
      end else begin
        mh = mh + 1;
      end
    end
  end

  task automatic check1(input string tag, input string name, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0b expected %0b", tag, name, $time, act, exp);
    end
  endtask

  // Compare away from the active edge, every cycle (R10 latency)
  always @(negedge clk) begin
    if (!done) begin
      if (in_rst) begin
        check1("R1", "hsync_o", hsync_o, e_hs);
        check1("R1", "hblank_o", hblank_o, e_hb);
        check1("R1", "vsync_o", vsync_o, e_vs);
        check1("R1", "vblank_o", vblank_o, e_vb);
        check1("R1", "field_o", field_o, e_fd);
        check1("R1", "user_h_o", user_h_o, e_uh);
        check1("R1", "user_v_o", user_v_o, e_uv);
      end else begin
        check1("R2 R3 R10", "hsync_o", hsync_o, e_hs);
        check1("R4 R10", "hblank_o", hblank_o, e_hb);
        check1("R5 R10", "vsync_o", vsync_o, e_vs);
        check1("R6 R10", "vblank_o", vblank_o, e_vb);
        check1("R7 R10", "field_o", field_o, e_fd);
        check1("R8 R10", "user_h_o", user_h_o, e_uh);
        check1("R9 R10", "user_v_o", user_v_o, e_uv);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    run(4);                       // R1 reset levels
    rst_n = 1'b1;
    run(480);                     // R2..R6 progressive, two frames
    pol_inv = 5'b11111;           // R3..R7 inverted senses
    run(240);
    pol_inv = 5'b00101;
    run(240);
    pol_inv = 5'd0;
    interlaced = 1'b1;            // R7 odd total: fields of 7 and 6 lines
    v_total = 15'd13; v_active = 15'd4; vs_start = 15'd5; vs_stop = 15'd6;
    run(520);
    pol_inv = 5'b10000;
    run(260);
    pol_inv = 5'd0;
    interlaced = 1'b0;
    v_total = 15'd12; v_active = 15'd8; vs_start = 15'd9; vs_stop = 15'd10;
    uh_start = 16'd3; uh_stop = 16'd9; uv_start = 15'd2; uv_stop = 15'd5;   // R8 R9 valid
    run(480);
    uh_stop = 16'd20; uv_stop = 15'd12;                                    // limits exactly met
    run(240);
    uh_start = 16'd9; uh_stop = 16'd3; uv_start = 15'd5; uv_stop = 15'd5;  // R8 R9 malformed
    run(240);
    uh_start = 16'd3; uh_stop = 16'd21; uv_start = 15'd2; uv_stop = 15'd13; // R8 R9 beyond raster
    run(240);
    hs_start = 16'd17; hs_stop = 16'd15;                                   // R3 malformed sync
    h_total = 16'd9; h_active = 16'd6;                                     // R2 shorter line
    run(300);
    rst_n = 1'b0;                                                          // R1 reset mid-run
    run(3);
    rst_n = 1'b1;
    run(60);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired at %0t: actual hung expected finished", $time);
    finish_run();
  end

endmodule